// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block keeps the status byte of a serial non-volatile memory and decides, cycle by cycle, whether an array write or a status write may begin. The command decoder ahead of it sends single-cycle strobes: set the write-enable latch, clear it, commit an array write at a given address, or commit a status write with a data byte. It also passes through the level of the hardware lock pin. The unit answers with two permit signals and a live status byte. A separate programming timer sends a one-cycle completion pulse when the internal program interval ends.

A small sequencer tracks the program cycle. It has three named states. `ST_IDLE` means no programming is under way. `ST_ARRAY_PROG` means an array write is in progress. `ST_STATUS_PROG` means a status write is in progress. The transitions are named as follows. `IDLE->ARRAY_PROG` happens on a permitted array commit. `IDLE->STATUS_PROG` happens on a permitted status commit when no array commit is present in the same cycle. `ARRAY_PROG->IDLE` and `STATUS_PROG->IDLE` both happen on the completion pulse. Every other combination holds the current state.

Non-volatile bits are modelled as ordinary flops that reset to zero. Status data captured at commit is held pending and written into the register on completion.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset, the status byte reads 0x00 and both permit outputs are 0.
- R2: The status byte is laid out as follows: bit 7 is the lock-enable bit, bits 3:2 are the range-guard field, bit 1 is the write-enable latch, and bit 0 is the write-in-progress flag. Bits 6:4 always read 0.
- R3: A set strobe sets the latch on the next cycle. A clear strobe clears it. If both arrive in the same cycle, clear wins. Both strobes work even while the hardware lock is active.
- R4: While the latch is 0, both permit outputs are 0 whatever the address, pin or status bits.
- R5: The array permit is 0 for a protected address, as set by the guard field. Guard 00 protects no addresses. Guard 01 protects 0x1800-0x1FFF. Guard 10 protects 0x1000-0x1FFF. Guard 11 protects every address.
- R6: The hardware lock is active when the pin is low and bit 7 is 1. While it is active, the status permit is 0. Array writes to unprotected addresses are still permitted.
- R7: A permitted array commit sets bit 0 from the next cycle on. Bit 0 stays set until a completion pulse. In the cycle after that pulse, bits 0 and 1 both read 0.
- R8: A permitted status commit sets bit 0 in the same way as an array commit. On completion, data bits 7 and 3:2 are written into the register. The other data bits are ignored, and the latch is cleared.
- R9: Once a status write has been committed, the pin going low does not stop it: the new value is still written on completion.
- R10: While bit 0 is 1, both permits are 0, and commits and further data are ignored. The status byte stays readable and shows bit 0 as 1.
- R11: A commit that is not permitted leaves the status byte unchanged.
- R12: A completion pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (models power-up) |
| en_set_i | input | 1 | Strobe: set write-enable latch |
| en_clr_i | input | 1 | Strobe: clear write-enable latch |
| stat_wr_i | input | 1 | Strobe: commit status write |
| stat_data_i | input | 8 | Data byte for status write |
| lock_pin_n_i | input | 1 | Hardware lock pin, active low |
| wr_addr_i | input | ADDR_W | Candidate array address |
| arr_wr_i | input | 1 | Strobe: commit array write at wr_addr_i |
| cycle_done_i | input | 1 | One-cycle completion pulse from the program timer |
| status_o | output | 8 | Live status byte |
| arr_permit_o | output | 1 | Array write allowed at wr_addr_i |
| stat_permit_o | output | 1 | Status write allowed |

## Verification
The properties assume the following about the inputs. Strobes are single-cycle pulses. The timer raises the completion pulse only when the unit has reported a program cycle in progress. The candidate address is held steady while a commit is presented. The idle-completion property further assumes that no strobe accompanies the stray pulse. The stimulus follows these rules. It drives all inputs at the falling edge, issues each strobe for exactly one cycle, and sends completion pulses only after checking bit 0. Stray pulses and conflicting strobe pairs appear only in the cases written to test them.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ARRAY_PROG  = 2'd1,
        ST_STATUS_PROG = 2'd2
    } prog_state_e;

    localparam int STAT_W     = 8;
    localparam int LOCK_BIT   = 7;
    localparam int GUARD_HI   = 3;
    localparam int GUARD_LO   = 2;
    localparam int LATCH_BIT  = 1;
    localparam int BUSY_BIT   = 0;

    // bits that a status write may change
    localparam logic [STAT_W-1:0] NV_MASK =
        (STAT_W'(1) << LOCK_BIT) | (STAT_W'(1) << GUARD_HI) | (STAT_W'(1) << GUARD_LO);

endpackage

// File: rtl/sr_wp_guard.sv
module sr_wp_guard #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        guard_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              blocked_o
);
    localparam int TOP = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign upper_half    = addr_i[TOP];
            assign upper_quarter = addr_i[TOP] & addr_i[TOP-1];
        end else begin : g_narrow
            assign upper_half    = addr_i[TOP];
            assign upper_quarter = addr_i[TOP];
        end
    endgenerate

    always_comb begin
        unique case (guard_i)
            2'b00:   blocked_o = 1'b0;
            2'b01:   blocked_o = upper_quarter;
            2'b10:   blocked_o = upper_half;
            default: blocked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_wp_seq.sv
module sr_wp_seq
    import sr_wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arr_go_i,
    input  logic stat_go_i,
    input  logic done_i,
    output logic busy_o,
    output logic finish_o,
    output logic stat_finish_o
);
    prog_state_e state_q;
    prog_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arr_go_i)       state_d = ST_ARRAY_PROG;
                else if (stat_go_i) state_d = ST_STATUS_PROG;
            end
            ST_ARRAY_PROG: begin
                if (done_i) state_d = ST_IDLE;
            end
            ST_STATUS_PROG: begin
                if (done_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy_o        = 1'b0;
        finish_o      = 1'b0;
        stat_finish_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_ARRAY_PROG: begin
                busy_o   = 1'b1;
                finish_o = done_i;
            end
            ST_STATUS_PROG: begin
                busy_o        = 1'b1;
                finish_o      = done_i;
                stat_finish_o = done_i;
            end
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sr_wp_regs.sv
module sr_wp_regs
    import sr_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              finish_i,
    input  logic              stat_go_i,
    input  logic              stat_finish_i,
    input  logic [STAT_W-1:0] data_i,
    output logic              latch_o,
    output logic [STAT_W-1:0] nv_o
);
    logic [STAT_W-1:0] pend_q;
    logic [STAT_W-1:0] nv_q;
    logic              latch_q;

    // write-enable latch: completion beats clear beats set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (finish_i) latch_q <= 1'b0;
        else if (clr_i)    latch_q <= 1'b0;
        else if (set_i)    latch_q <= 1'b1;
    end

    // captured data waits for the end of the program interval
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pend_q <= '0;
        else if (stat_go_i) pend_q <= data_i & NV_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             nv_q <= '0;
        else if (stat_finish_i) nv_q <= pend_q;
    end

    assign latch_o = latch_q;
    assign nv_o    = nv_q;
endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
    import sr_wp_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        stat_data_i,
    input  logic              lock_pin_n_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              arr_wr_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              arr_permit_o,
    output logic              stat_permit_o
);
    logic              busy;
    logic              finish;
    logic              stat_finish;
    logic              latch;
    logic [STAT_W-1:0] nv;
    logic              blocked;
    logic              hw_lock;
    logic              arr_go;
    logic              stat_go;

    sr_wp_guard #(.ADDR_W(ADDR_W)) i_guard (
        .guard_i   (nv[GUARD_HI:GUARD_LO]),
        .addr_i    (wr_addr_i),
        .blocked_o (blocked)
    );

    assign hw_lock       = nv[LOCK_BIT] & ~lock_pin_n_i;
    assign arr_permit_o  = latch & ~busy & ~blocked;
    assign stat_permit_o = latch & ~busy & ~hw_lock;
    assign arr_go        = arr_wr_i & arr_permit_o;
    assign stat_go       = stat_wr_i & stat_permit_o & ~arr_wr_i;

    sr_wp_seq i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .arr_go_i      (arr_go),
        .stat_go_i     (stat_go),
        .done_i        (cycle_done_i),
        .busy_o        (busy),
        .finish_o      (finish),
        .stat_finish_o (stat_finish)
    );

    sr_wp_regs i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_i         (en_set_i),
        .clr_i         (en_clr_i),
        .finish_i      (finish),
        .stat_go_i     (stat_go),
        .stat_finish_i (stat_finish),
        .data_i        (stat_data_i),
        .latch_o       (latch),
        .nv_o          (nv)
    );

    assign status_o = nv | {{(STAT_W-2){1'b0}}, latch, busy};
endmodule

// File: rtl/sr_wp_unit_chk.sv
module sr_wp_unit_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_set_i,
    input logic              en_clr_i,
    input logic              stat_wr_i,
    input logic              arr_wr_i,
    input logic              lock_pin_n_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              cycle_done_i,
    input logic [7:0]        status_o,
    input logic              arr_permit_o,
    input logic              stat_permit_o
);
    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_i |=> !status_o[1]);

    assert_latch_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> (!arr_permit_o && !stat_permit_o));

    assert_full_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> !arr_permit_o);

    assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !lock_pin_n_i) |-> !stat_permit_o);

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_i && arr_permit_o) |=> status_o[0]);

    assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && cycle_done_i) |=> (!status_o[0] && !status_o[1]));

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> (!arr_permit_o && !stat_permit_o));

    assert_idle_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[0] && cycle_done_i && !arr_wr_i && !stat_wr_i && !en_set_i && !en_clr_i)
        |=> $stable(status_o));

    logic unused_addr;
    assign unused_addr = ^wr_addr_i;
endmodule

bind sr_wp_unit sr_wp_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_set_i      (en_set_i),
    .en_clr_i      (en_clr_i),
    .stat_wr_i     (stat_wr_i),
    .arr_wr_i      (arr_wr_i),
    .lock_pin_n_i  (lock_pin_n_i),
    .wr_addr_i     (wr_addr_i),
    .cycle_done_i  (cycle_done_i),
    .status_o      (status_o),
    .arr_permit_o  (arr_permit_o),
    .stat_permit_o (stat_permit_o)
);

// File: tb/test_sr_wp_unit.sv
module test_sr_wp_unit;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_set_i = 1'b0;
    logic              en_clr_i = 1'b0;
    logic              stat_wr_i = 1'b0;
    logic [7:0]        stat_data_i = 8'h00;
    logic              lock_pin_n_i = 1'b1;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic              arr_wr_i = 1'b0;
    logic              cycle_done_i = 1'b0;
    logic [7:0]        status_o;
    logic              arr_permit_o;
    logic              stat_permit_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    sr_wp_unit #(.ADDR_W(ADDR_W)) i_sr_wp_unit (.*);

    // behavioural reference model
    bit m_wel, m_busy, m_is_stat, m_pen, m_ppen;
    int m_guard, m_pguard;

    function automatic bit m_blocked(int addr);
        case (m_guard)
            0:       return 0;
            1:       return addr >= 'h1800;
            2:       return addr >= 'h1000;
            default: return 1;
        endcase
    endfunction
    function automatic bit m_arr_ok();
        return m_wel && !m_busy && !m_blocked(int'(wr_addr_i));
    endfunction
    function automatic bit m_stat_ok();
        return m_wel && !m_busy && !(m_pen && !lock_pin_n_i);
    endfunction
    function automatic logic [7:0] m_status();
        return {m_pen, 3'b000, 2'(m_guard), m_wel, m_busy};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wel <= 0; m_busy <= 0; m_is_stat <= 0;
            m_pen <= 0; m_ppen <= 0; m_guard <= 0; m_pguard <= 0;
        end else begin
            if (m_busy && cycle_done_i) begin
                m_busy <= 0;
                m_wel  <= 0;
                if (m_is_stat) begin
                    m_pen   <= m_ppen;
                    m_guard <= m_pguard;
                end
            end else begin
                if (en_clr_i)      m_wel <= 0;
                else if (en_set_i) m_wel <= 1;
                if (arr_wr_i && m_arr_ok()) begin
                    m_busy <= 1; m_is_stat <= 0;
                end else if (stat_wr_i && !arr_wr_i && m_stat_ok()) begin
                    m_busy <= 1; m_is_stat <= 1;
                    m_ppen <= stat_data_i[7];
                    m_pguard <= int'(stat_data_i[3:2]);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check("model status", status_o, m_status());
        check("model arr_permit", 8'(arr_permit_o), 8'(m_arr_ok()));
        check("model stat_permit", 8'(stat_permit_o), 8'(m_stat_ok()));
    endtask

    task automatic pulse_set();  en_set_i = 1; tick(); en_set_i = 0; endtask
    task automatic pulse_done(); cycle_done_i = 1; tick(); cycle_done_i = 0; endtask
    task automatic stat_write(input logic [7:0] d);
        stat_data_i = d; stat_wr_i = 1; tick(); stat_wr_i = 0; stat_data_i = 8'h00;
    endtask
    task automatic arr_write(input logic [ADDR_W-1:0] a);
        wr_addr_i = a; arr_wr_i = 1; tick(); arr_wr_i = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 reset status", status_o, 8'h00);
        check("R1 reset permits", {6'b0, arr_permit_o, stat_permit_o}, 8'h00);
        rst_n = 1;
        tick();

        pulse_set();
        check("R3 set latch", status_o, 8'h02);
        check("R4 permit with latch", 8'(arr_permit_o), 8'h01);
        en_set_i = 1; en_clr_i = 1; tick(); en_set_i = 0; en_clr_i = 0;
        check("R3 clear wins", status_o, 8'h00);
        check("R4 latch low blocks", {6'b0, arr_permit_o, stat_permit_o}, 8'h00);

        // status write, pin dropped mid-cycle
        pulse_set();
        stat_write(8'hFF);
        check("R8 status write busy", status_o, 8'h03);
        check("R10 busy blocks", {6'b0, arr_permit_o, stat_permit_o}, 8'h00);
        lock_pin_n_i = 0;
        stat_write(8'h00);
        arr_write(13'h0000);
        check("R10 commits ignored busy", status_o, 8'h03);
        for (int i = 0; i < 4; i++) tick();
        check("R7 busy holds", status_o, 8'h03);
        pulse_done();
        check("R9 completes under pin low", status_o, 8'h8C);
        check("R8 spare bits ignored", 8'(status_o[6:4]), 8'h00);

        pulse_set();
        check("R3 set under lock", status_o, 8'h8E);
        check("R6 status locked", 8'(stat_permit_o), 8'h00);
        check("R5 guard 11 blocks 0", 8'(arr_permit_o), 8'h00);
        stat_write(8'h00);
        check("R11 locked write ignored", status_o, 8'h8E);

        lock_pin_n_i = 1; tick();
        check("R6 pin high unlocks", 8'(stat_permit_o), 8'h01);
        stat_write(8'h04);
        pulse_done();
        check("R8 guard 01 loaded", status_o, 8'h04);

        pulse_set();
        wr_addr_i = 13'h17FF; tick();
        check("R5 0x17FF open", 8'(arr_permit_o), 8'h01);
        wr_addr_i = 13'h1800; tick();
        check("R5 0x1800 guarded", 8'(arr_permit_o), 8'h00);
        arr_write(13'h1800);
        check("R11 guarded write ignored", status_o, 8'h06);
        arr_write(13'h17FF);
        check("R7 array busy", status_o, 8'h07);
        pulse_done();
        check("R7 completion clears", status_o, 8'h04);

        cycle_done_i = 1; tick(); cycle_done_i = 0;
        check("R12 idle pulse no effect", status_o, 8'h04);

        pulse_set();
        stat_write(8'h88);
        pulse_done();
        check("R8 guard 10 lock on", status_o, 8'h88);
        lock_pin_n_i = 0;
        pulse_set();
        wr_addr_i = 13'h0FFF; tick();
        check("R6 array open under lock", 8'(arr_permit_o), 8'h01);
        check("R6 status blocked", 8'(stat_permit_o), 8'h00);
        wr_addr_i = 13'h1000; tick();
        check("R5 0x1000 guarded", 8'(arr_permit_o), 8'h00);
        check("R2 layout", status_o, 8'h8A);

        lock_pin_n_i = 1;
        en_clr_i = 1; tick(); en_clr_i = 0;
        check("R3 clear strobe", status_o, 8'h88);

        ended = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule